// File: doc/BRIEF.md
# Comma Word Aligner with Link Synchronization

This block sits on one receive lane directly after a 10-bit deserializer. Each clock it takes a raw 10-bit word whose bit boundary is arbitrary, keeps the previous word beside it, and scans all ten bit offsets of that 20-bit window for a comma. The first comma it finds sets the word boundary. From then on every code group leaves the block correctly framed, one per clock.

A link synchronization state machine tracks progress. It starts in a hunting state. A comma moves it into acquisition, and four commas at the same boundary, with any number of ordinary code groups between them, move it into the locked state. While locked, the boundary cannot move. An error budget that tolerates isolated faults decides when lock is given up. The downstream decoder feeds its invalid-code and disparity-error flags back in. A signal-present input from the analog front end overrides everything else.

Top module: `comma_lane_aligner`

## Requirements
- R1: A comma is a code group whose first seven bits (bits 9 down to 3, bit 9 received first) are 0011111 or its complement 1100000. This covers K28.1, K28.5 and K28.7 in both disparities. A stream free of these patterns never leads to lock.
- R2: The comma search covers all ten bit offsets 0 to 9 of the window formed by the previous and the current input word. While hunting, the boundary is set to the offset at which a comma is found.
- R3: The code group whose first bit lies in the input word sampled at rising edge N appears on `aligned_word`, framed at the selected boundary, after rising edge N+2.
- R4: `sync_status` rises when the fourth comma at the chosen boundary is received, in the same cycle that comma appears on `aligned_word`. Non-comma code groups between the commas do not reset the count.
- R5: During acquisition, a code group flagged invalid or with a disparity error discards the commas counted so far. Four further commas are then needed.
- R6: When `sig_ok` is sampled low, `sync_status` is low after that edge and the comma search starts again from hunting.
- R7: While locked, a code group is bad if it is flagged invalid, flagged with a disparity error, or if a comma is seen at an offset other than the locked one. Lock is lost, and `sync_status` falls after the edge at which the fourth net bad code group is sampled.
- R8: While locked with at least one bad code group accumulated, four consecutive good code groups cancel one of them.
- R9: While locked, a comma at another offset does not move the boundary. The code groups around it still leave at the locked offset.
- R10: During reset, `sync_status` and `aligned_word` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_word | input | 10 | Unaligned word from the deserializer, bit 9 received first |
| sig_ok | input | 1 | Signal present on the lane |
| code_bad | input | 1 | Decoder flag: invalid code group |
| disp_bad | input | 1 | Decoder flag: running disparity error |
| aligned_word | output | 10 | Code group framed at the selected boundary |
| sync_status | output | 1 | Lane is synchronized |

## Verification
The bench builds the block with its default parameters: four commas to acquire, four net bad code groups to lose lock, four good code groups to cancel one, and both comma polarities enabled. These defaults put the boundary counts within reach of short hand-built sequences. Examples are three bad groups that keep lock against a fourth that drops it, and a cancelled error that turns that fourth bad group back into a survivable one. Bit streams are shifted by offsets 0, 3, 5, 7 and 9, so both ends of the search window and interior offsets are exercised. A misaligned comma injected while locked tests that the boundary stays frozen.

// File: rtl/la_pkg.sv
`timescale 1ns/1ps
package la_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_ACQ  = 2'd1,
      ST_LOCK = 2'd2
   } align_st_t;

   localparam int COMMA_W = 7;
   localparam logic [COMMA_W-1:0] COMMA_POS = 7'b0011111;
endpackage

// File: rtl/comma_scan.sv
`timescale 1ns/1ps
module comma_scan #(
   parameter int W    = 10,
   parameter int CW   = 7,
   parameter bit DUAL = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   rx_word,
   output logic [2*W-1:0] win,
   output logic [W-1:0]   hits
);
   logic [W-1:0] cur_q;
   logic [W-1:0] old_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         old_q <= '0;
      end else begin
         cur_q <= rx_word;
         old_q <= cur_q;
      end
   end

   assign win = {old_q, cur_q};

   for (genvar k = 0; k < W; k++) begin : g_off
      logic [CW-1:0] seg;
      assign seg = win[2*W-1-k -: CW];
      if (DUAL) begin : g_both
         assign hits[k] = (seg == la_pkg::COMMA_POS) || (seg == ~la_pkg::COMMA_POS);
      end else begin : g_pos
         assign hits[k] = (seg == la_pkg::COMMA_POS);
      end
   end
endmodule

// File: rtl/lane_sync_fsm.sv
`timescale 1ns/1ps
module lane_sync_fsm #(
   parameter int W          = 10,
   parameter int OFF_W      = 4,
   parameter int ACQ_COMMAS = 4,
   parameter int LOSS_ERRS  = 4,
   parameter int GOOD_RUN   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     hits,
   input  logic             sig_ok,
   input  logic             code_bad,
   input  logic             disp_bad,
   output logic [OFF_W-1:0] bnd_next,
   output logic             in_sync
);
   import la_pkg::*;

   localparam int CC_W = $clog2(ACQ_COMMAS + 1);
   localparam int ER_W = $clog2(LOSS_ERRS + 1);
   localparam int RN_W = $clog2(GOOD_RUN + 1);
   localparam logic [CC_W-1:0] CC_ONE  = CC_W'(1);
   localparam logic [CC_W-1:0] CC_LAST = CC_W'(ACQ_COMMAS - 1);
   localparam logic [ER_W-1:0] ER_LAST = ER_W'(LOSS_ERRS - 1);
   localparam logic [RN_W-1:0] RN_LAST = RN_W'(GOOD_RUN - 1);

   align_st_t        st_q, st_n;
   logic [OFF_W-1:0] bnd_q, bnd_n, first_idx;
   logic [CC_W-1:0]  cc_q, cc_n;
   logic [ER_W-1:0]  er_q, er_n;
   logic [RN_W-1:0]  rn_q, rn_n;
   logic             any_hit, at_bnd, stray, bad_code;

   always_comb begin
      first_idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (hits[i]) first_idx = OFF_W'(i);
      end
   end

   assign any_hit  = |hits;
   assign at_bnd   = hits[bnd_q];
   assign stray    = |(hits & ~(W'(1) << bnd_q));
   assign bad_code = code_bad | disp_bad;

   always_comb begin
      st_n  = st_q;
      bnd_n = bnd_q;
      cc_n  = cc_q;
      er_n  = er_q;
      rn_n  = rn_q;
      case (st_q)
         ST_HUNT: begin
            er_n = '0;
            rn_n = '0;
            if (any_hit) begin
               bnd_n = first_idx;
               cc_n  = CC_ONE;
               st_n  = ST_ACQ;
            end
         end
         ST_ACQ: begin
            if (bad_code) begin
               st_n = ST_HUNT;
               cc_n = '0;
            end else if (at_bnd) begin
               if (cc_q == CC_LAST) begin
                  st_n = ST_LOCK;
                  er_n = '0;
                  rn_n = '0;
               end else begin
                  cc_n = cc_q + CC_ONE;
               end
            end else if (stray) begin
               bnd_n = first_idx;
               cc_n  = CC_ONE;
            end
         end
         ST_LOCK: begin
            if (bad_code || stray) begin
               rn_n = '0;
               if (er_q == ER_LAST) begin
                  st_n = ST_HUNT;
                  cc_n = '0;
                  er_n = '0;
               end else begin
                  er_n = er_q + ER_W'(1);
               end
            end else if (er_q != '0) begin
               if (rn_q == RN_LAST) begin
                  rn_n = '0;
                  er_n = er_q - ER_W'(1);
               end else begin
                  rn_n = rn_q + RN_W'(1);
               end
            end
         end
         default: st_n = ST_HUNT;
      endcase
      if (!sig_ok) begin
         st_n = ST_HUNT;
         cc_n = '0;
         er_n = '0;
         rn_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_HUNT;
         bnd_q <= '0;
         cc_q  <= '0;
         er_q  <= '0;
         rn_q  <= '0;
      end else begin
         st_q  <= st_n;
         bnd_q <= bnd_n;
         cc_q  <= cc_n;
         er_q  <= er_n;
         rn_q  <= rn_n;
      end
   end

   assign bnd_next = bnd_n;
   assign in_sync  = (st_q == ST_LOCK);

   // R6
   sig_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sig_ok |=> (st_q == ST_HUNT));

   // R9
   bnd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOCK) |=> $stable(bnd_q));

   // R4
   sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> $past(at_bnd));

   // R7
   err_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && er_q == ER_LAST && bad_code) |=> !in_sync);

   // R2
   bnd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bnd_q) < W);
endmodule

// File: rtl/word_select.sv
`timescale 1ns/1ps
module word_select #(
   parameter int W     = 10,
   parameter int OFF_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2*W-1:0]   win,
   input  logic [OFF_W-1:0] sel,
   output logic [W-1:0]     word_q
);
   logic [W-1:0] pick;

   always_comb begin
      for (int i = 0; i < W; i++) begin
         pick[i] = win[W + i - int'(sel)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= pick;
   end
endmodule

// File: rtl/comma_lane_aligner.sv
`timescale 1ns/1ps
module comma_lane_aligner #(
   parameter int WORD_W     = 10,
   parameter int ACQ_COMMAS = 4,
   parameter int LOSS_ERRS  = 4,
   parameter int GOOD_RUN   = 4,
   parameter bit DUAL_POL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              sig_ok,
   input  logic              code_bad,
   input  logic              disp_bad,
   output logic [WORD_W-1:0] aligned_word,
   output logic              sync_status
);
   localparam int OFF_W = $clog2(WORD_W);

   if (WORD_W != 10) begin : g_bad_width
      $error("comma_lane_aligner: WORD_W must be 10 for 8b/10b code groups");
   end
   if (ACQ_COMMAS < 2) begin : g_bad_acq
      $error("comma_lane_aligner: ACQ_COMMAS must be at least 2");
   end
   if (LOSS_ERRS < 1 || GOOD_RUN < 1) begin : g_bad_err
      $error("comma_lane_aligner: LOSS_ERRS and GOOD_RUN must be at least 1");
   end

   logic [2*WORD_W-1:0] win;
   logic [WORD_W-1:0]   hits;
   logic [OFF_W-1:0]    bnd_next;

   comma_scan #(.W(WORD_W), .CW(la_pkg::COMMA_W), .DUAL(DUAL_POL)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_word (rx_word),
      .win     (win),
      .hits    (hits)
   );

   lane_sync_fsm #(
      .W(WORD_W), .OFF_W(OFF_W), .ACQ_COMMAS(ACQ_COMMAS),
      .LOSS_ERRS(LOSS_ERRS), .GOOD_RUN(GOOD_RUN)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .hits     (hits),
      .sig_ok   (sig_ok),
      .code_bad (code_bad),
      .disp_bad (disp_bad),
      .bnd_next (bnd_next),
      .in_sync  (sync_status)
   );

   word_select #(.W(WORD_W), .OFF_W(OFF_W)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .win    (win),
      .sel    (bnd_next),
      .word_q (aligned_word)
   );
endmodule

// File: tb/sim_comma_lane_aligner.sv
`timescale 1ns/1ps
module sim_comma_lane_aligner;
   localparam logic [9:0] K5N = 10'b0011111010;
   localparam logic [9:0] K5P = 10'b1100000101;
   localparam logic [9:0] K1N = 10'b0011111001;
   localparam logic [9:0] K1P = 10'b1100000110;
   localparam logic [9:0] K7N = 10'b0011111000;
   localparam logic [9:0] K7P = 10'b1100000111;
   localparam logic [9:0] DA  = 10'b1010101010;
   localparam logic [9:0] DB  = 10'b1001110100;
   localparam logic [9:0] SA  = 10'b0000000111;
   localparam logic [9:0] SB  = 10'b1100000000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] rx_word = '0;
   logic       sig_ok = 1'b1;
   logic       code_bad = 1'b0;
   logic       disp_bad = 1'b0;
   logic [9:0] aligned_word;
   logic       sync_status;

   int  checks = 0;
   int  fails = 0;
   bit  chk_en = 1'b0;
   bit  bq[$];
   logic [9:0] expq[$];

   always #4 clk = ~clk;

   comma_lane_aligner u0 (
      .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .sig_ok(sig_ok),
      .code_bad(code_bad), .disp_bad(disp_bad),
      .aligned_word(aligned_word), .sync_status(sync_status)
   );

   // scoreboard monitor: R3 framing and latency, R9 frozen boundary
   always @(posedge clk) begin
      #2;
      if (expq.size() >= 3) begin
         logic [9:0] e;
         e = expq.pop_front();
         if (chk_en && sync_status) begin
            checks++;
            if (aligned_word !== e) begin
               fails++;
               $display("FAIL R3/R9 aligned_word actual=%b expected=%b", aligned_word, e);
            end
         end
      end
   end

   task automatic start_stream(input int s);
      bq.delete();
      expq.delete();
      repeat (s) bq.push_back(1'b0);
   endtask

   task automatic send(input logic [9:0] g, input bit cb = 0, input bit db = 0,
                       input bit so = 1);
      logic [9:0] w;
      for (int j = 9; j >= 0; j--) bq.push_back(g[j]);
      for (int j = 9; j >= 0; j--) w[j] = bq.pop_front();
      rx_word  = w;
      code_bad = cb;
      disp_bad = db;
      sig_ok   = so;
      expq.push_back(g);
      @(negedge clk);
   endtask

   task automatic chk_sync(input bit exp, input string tag);
      checks++;
      if (sync_status !== exp) begin
         fails++;
         $display("FAIL %s sync_status actual=%b expected=%b", tag, sync_status, exp);
      end
   endtask

   task automatic acquire(input logic [9:0] ka, input logic [9:0] kb);
      send(ka); send(DA); send(kb); send(DA); send(DB);
      send(ka); chk_sync(0, "R4 three commas");
      send(DA); send(kb);
      chk_sync(0, "R4 fourth comma not yet out");
      send(DA); chk_sync(0, "R4 one edge later");
      send(DB); chk_sync(1, "R4 rises with fourth comma");
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      chk_sync(0, "R10 reset");
      checks++;
      if (aligned_word !== 10'd0) begin
         fails++;
         $display("FAIL R10 aligned_word actual=%b expected=%b", aligned_word, 10'd0);
      end
      rst_n = 1'b1;
      chk_en = 1'b1;

      // offset 3, K28.5 both disparities
      start_stream(3);
      acquire(K5N, K5P);
      send(DA); send(DB); send(DA); send(DB);

      // R9: comma at foreign offset while locked
      send(SA); send(SB);
      repeat (6) send(DA);
      chk_sync(1, "R9 stray comma tolerated");

      // R7 and R8
      send(DA, 1, 0); send(DA, 0, 1); send(DA, 1, 0);
      chk_sync(1, "R7 three bad groups keep lock");
      repeat (4) send(DB);
      send(DA, 0, 1);
      chk_sync(1, "R8 cancelled error keeps lock");
      send(DA, 1, 0);
      chk_sync(0, "R7 fourth net bad group drops lock");

      // R6: relock then drop the signal
      acquire(K5P, K5N);
      send(DA);
      send(DA, 0, 0, 0);
      chk_sync(0, "R6 signal loss");

      // offset 7, K28.1
      start_stream(7);
      acquire(K1N, K1P);
      send(DA); send(DB); send(DA);
      send(DA, 0, 0, 0);
      chk_sync(0, "R6 signal loss 2");

      // offset 0, K28.7
      start_stream(0);
      acquire(K7N, K7P);
      send(DA); send(DB); send(DA);
      send(DA, 0, 0, 0);

      // offset 9, no commas first
      start_stream(9);
      repeat (8) send(DA);
      repeat (4) send(DB);
      chk_sync(0, "R1 comma-free stream");
      acquire(K5N, K1P);
      send(DA); send(DB); send(DA);
      send(DA, 0, 0, 0);

      // R5: error during acquisition, offset 5
      start_stream(5);
      send(K5N); send(DA); send(K5N); send(DA); send(K5N); send(DA); send(DA);
      send(DA, 1, 0); send(DA); send(DA);
      send(K5N); send(DA); send(K5N); send(DA); send(K5N); send(DA); send(DA); send(DA);
      chk_sync(0, "R5 count restarted after error");
      send(K5N); send(DA); send(DA);
      chk_sync(1, "R5 fourth comma after restart");
      send(DB); send(DA); send(DB);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule